// File: doc/BRIEF.md
# UART Channel Register Interface

This block sits between a byte-wide processor bus and the serial datapath of one UART channel. It decodes a 64-byte register window in which several offsets are direction-decoded: a read returns one register and a write loads a different one. Two mode registers share a single offset and are chosen by an internal pointer that advances on its own after the first mode register is touched. A command write can return the pointer to the first mode register.

Two further offsets act as commands rather than storage: a write to one sets output-port bits and a write to the other clears them, bit by bit, under the written data. Output-port bit 0 drives the RTS line. When the receiver flow-control bit in mode register 1 is on, a start bit that arrives while the receive FIFO is full drops RTS, and RTS comes back once the FIFO has room again. The receive FIFO is represented only by an occupancy counter. Reading the receive buffer pops it, and the entry data comes from the datapath.

All configuration values (both mode bytes, clock select, auxiliary control, prescale bytes, interrupt mask and vector, transmit byte with a load strobe, output-port bits) are presented as outputs to the datapath.

Top module: `uart_regif`

## Requirements
- R1: After reset, mode register 1, mode register 2, interrupt mask, clock select, auxiliary control, both prescale bytes and all output-port bits are 0x00, the interrupt vector is 0x0F, the pointer selects mode register 1 and the receive FIFO is empty.
- R2: Offset 0x00 accesses mode register 1 while the pointer selects it; any read or write of mode register 1 moves the pointer to mode register 2, and later accesses at 0x00 stay on mode register 2.
- R3: A write to offset 0x08 whose bits 6:4 equal 3'b001 returns the pointer to mode register 1; any other value in bits 6:4 leaves the pointer unchanged.
- R4: Direction-decoded offsets: at 0x04 a write loads clock select and a read returns status; at 0x10 a write loads auxiliary control and a read returns the input-port change byte; at 0x14 a write loads the interrupt mask and a read returns interrupt status; at 0x0C a write loads the transmit byte and pulses the transmit load output high for exactly the one cycle after the write.
- R5: Offsets 0x18 (prescale high), 0x1C (prescale low) and 0x30 (interrupt vector) read back what was last written; offset 0x34 reads the input-port pins and a write there changes nothing.
- R6: A write to 0x38 sets each output-port bit whose data bit is 1; a write to 0x3C clears each output-port bit whose data bit is 1; data bits of 0 leave their output bits unchanged.
- R7: A receive push raises the FIFO count by one unless the count equals the depth (4 by default); a read of 0x0C returns the head byte and lowers the count when not empty, and returns 0x00 without change when empty. The status read at 0x04 carries FIFO-not-empty in bit 0, FIFO-full in bit 1 and the status input in bits 7:2.
- R8: With mode register 1 bit 7 set, a receive start pulse while the FIFO is full clears output-port bit 0 (RTS) at the next edge, and RTS is set again two cycles after the pop that frees a position.
- R9: With mode register 1 bit 7 clear, receive start pulses never change RTS; only the set and clear commands do.
- R10: Reads of 0x08, 0x38, 0x3C and unused offsets return 0x00 and neither move the pointer nor pop the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the access cycle |
| stat_hi_in | input | 6 | Status bits 7:2 from the datapath |
| ipchg_in | input | 8 | Input-port change byte |
| irq_stat_in | input | 8 | Interrupt status byte |
| inport_in | input | 8 | Input-port pin levels |
| rx_head_in | input | 8 | Byte at the head of the receive FIFO |
| rx_push | input | 1 | Receiver stores a character |
| rx_start | input | 1 | Receiver saw a valid start bit |
| mode1_out | output | 8 | Mode register 1 |
| mode2_out | output | 8 | Mode register 2 |
| clk_sel_out | output | 8 | Clock select |
| aux_ctl_out | output | 8 | Auxiliary control |
| irq_mask_out | output | 8 | Interrupt mask |
| irq_vec_out | output | 8 | Interrupt vector |
| pre_hi_out | output | 8 | Baud prescale high byte |
| pre_lo_out | output | 8 | Baud prescale low byte |
| tx_data_out | output | 8 | Transmit byte |
| tx_load_out | output | 1 | One-cycle pulse after a transmit write |
| outport_out | output | 8 | Output-port bits |
| rts_out | output | 1 | RTS level, equal to output-port bit 0 |

## Verification
Read data is combinational and is due within the access cycle, so the bench samples it one time step after driving the access, before the clock edge. Register, pointer, FIFO count and output-port changes, along with the transmit load pulse, appear at the edge that ends the access and are checked at the following falling edge. The RTS return is due one edge after the pop, because the pop and the refill of RTS are each one register stage, so the bench checks that RTS is still low at the first falling edge after the pop and high at the second. Random register and output-port traffic is compared against a bench model after every access.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int DW = 8;
  localparam int AW = 6;

  localparam logic [AW-1:0] OFS_MODE     = 6'h00;
  localparam logic [AW-1:0] OFS_STAT_CS  = 6'h04;
  localparam logic [AW-1:0] OFS_CMD      = 6'h08;
  localparam logic [AW-1:0] OFS_RXTX     = 6'h0C;
  localparam logic [AW-1:0] OFS_CHG_AUX  = 6'h10;
  localparam logic [AW-1:0] OFS_IRQ      = 6'h14;
  localparam logic [AW-1:0] OFS_PRE_HI   = 6'h18;
  localparam logic [AW-1:0] OFS_PRE_LO   = 6'h1C;
  localparam logic [AW-1:0] OFS_VEC      = 6'h30;
  localparam logic [AW-1:0] OFS_INPORT   = 6'h34;
  localparam logic [AW-1:0] OFS_OP_SET   = 6'h38;
  localparam logic [AW-1:0] OFS_OP_CLR   = 6'h3C;

  localparam logic [2:0]    CMD_PTR_HOME = 3'b001;
  localparam logic [DW-1:0] VEC_RESET    = 8'h0F;

  typedef struct packed {
    logic       rx_flow;
    logic       rx_irq_sel;
    logic       err_mode;
    logic [1:0] par_mode;
    logic       par_type;
    logic [1:0] char_len;
  } mode1_t;
endpackage

// File: rtl/uart_regif_modeptr.sv
module uart_regif_modeptr
  import uart_regif_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_acc,
  input  logic          mode_wr,
  input  logic          ptr_home,
  input  logic [DW-1:0] wdata,
  output logic          sel_m2,
  output mode1_t        mode1,
  output logic [DW-1:0] mode2
);
  logic   sel_q, sel_nx;
  logic   m1_we, m2_we;
  mode1_t m1_q;
  logic [DW-1:0] m2_q;

  always_comb begin
    m1_we  = mode_acc && mode_wr && !sel_q;
    m2_we  = mode_acc && mode_wr &&  sel_q;
    sel_nx = sel_q;
    if (ptr_home)               sel_nx = 1'b0;
    else if (mode_acc && !sel_q) sel_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      m1_q  <= '0;
      m2_q  <= '0;
    end else begin
      sel_q <= sel_nx;
      if (m1_we) m1_q <= mode1_t'(wdata);
      if (m2_we) m2_q <= wdata;
    end
  end

  assign sel_m2 = sel_q;
  assign mode1  = m1_q;
  assign mode2  = m2_q;

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_acc && !sel_q && !ptr_home) |=> sel_q) else $error("ptr advance"); // R2
  AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_home |=> !sel_q) else $error("ptr home"); // R3
  AST_M1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !ptr_home) |=> $stable(m1_q)) else $error("mode1 changed"); // R2
endmodule

// File: rtl/uart_regif_rxcnt.sv
module uart_regif_rxcnt #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop_req,
  output logic empty,
  output logic full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic push_ok, pop_ok;

  always_comb begin
    push_ok = push && (cnt_q != FULL_LVL);
    pop_ok  = pop_req && (cnt_q != '0);
    cnt_nx  = cnt_q;
    if (push_ok && !pop_ok)      cnt_nx = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULL_LVL);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_LVL) else $error("fifo overflow"); // R7
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("pop"); // R7
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push && cnt_q == '0) |=> (cnt_q == '0)) else $error("empty pop"); // R7
endmodule

// File: rtl/uart_regif_outport.sv
module uart_regif_outport #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic [OPW-1:0] wdata,
  input  logic           flow_en,
  input  logic           rx_start,
  input  logic           fifo_full,
  output logic [OPW-1:0] op_bits
);
  logic [OPW-1:0] op_q, op_nx;
  logic hold_q, hold_nx;

  always_comb begin
    op_nx   = op_q;
    hold_nx = hold_q;
    if (set_we) op_nx = op_nx | wdata;
    if (clr_we) op_nx = op_nx & ~wdata;
    if (flow_en) begin
      if (rx_start && fifo_full) begin
        op_nx[0] = 1'b0;
        hold_nx  = 1'b1;
      end else if (hold_q && !fifo_full) begin
        op_nx[0] = 1'b1;
        hold_nx  = 1'b0;
      end
    end else begin
      hold_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      op_q   <= op_nx;
      hold_q <= hold_nx;
    end
  end

  assign op_bits = op_q;

  AST_OP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !flow_en) |=> ((op_q & $past(wdata)) == $past(wdata))) else $error("op set"); // R6
  AST_OP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !flow_en) |=> ((op_q & $past(wdata)) == '0)) else $error("op clr"); // R6
  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && rx_start && fifo_full) |=> !op_q[0]) else $error("rts drop"); // R8
  AST_RTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_en && !set_we && !clr_we) |=> $stable(op_q)) else $error("rts idle"); // R9
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-3:0] stat_hi_in,
  input  logic [DW-1:0] ipchg_in,
  input  logic [DW-1:0] irq_stat_in,
  input  logic [DW-1:0] inport_in,
  input  logic [DW-1:0] rx_head_in,
  input  logic          rx_push,
  input  logic          rx_start,
  output logic [DW-1:0] mode1_out,
  output logic [DW-1:0] mode2_out,
  output logic [DW-1:0] clk_sel_out,
  output logic [DW-1:0] aux_ctl_out,
  output logic [DW-1:0] irq_mask_out,
  output logic [DW-1:0] irq_vec_out,
  output logic [DW-1:0] pre_hi_out,
  output logic [DW-1:0] pre_lo_out,
  output logic [DW-1:0] tx_data_out,
  output logic          tx_load_out,
  output logic [DW-1:0] outport_out,
  output logic          rts_out
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic acc_wr, acc_rd;
  logic we_cs, we_aux, we_imr, we_hi, we_lo, we_vec, we_tx, we_set, we_clr;
  logic mode_acc, ptr_home, rd_rx;

  always_comb begin
    acc_wr   = bus_sel &&  bus_wr;
    acc_rd   = bus_sel && !bus_wr;
    we_cs    = acc_wr && (bus_addr == OFS_STAT_CS);
    we_aux   = acc_wr && (bus_addr == OFS_CHG_AUX);
    we_imr   = acc_wr && (bus_addr == OFS_IRQ);
    we_hi    = acc_wr && (bus_addr == OFS_PRE_HI);
    we_lo    = acc_wr && (bus_addr == OFS_PRE_LO);
    we_vec   = acc_wr && (bus_addr == OFS_VEC);
    we_tx    = acc_wr && (bus_addr == OFS_RXTX);
    we_set   = acc_wr && (bus_addr == OFS_OP_SET);
    we_clr   = acc_wr && (bus_addr == OFS_OP_CLR);
    mode_acc = bus_sel && (bus_addr == OFS_MODE);
    ptr_home = acc_wr && (bus_addr == OFS_CMD) && (bus_wdata[6:4] == CMD_PTR_HOME);
    rd_rx    = acc_rd && (bus_addr == OFS_RXTX);
  end

  logic   sel_m2;
  mode1_t mode1;
  logic   fifo_empty, fifo_full;

  uart_regif_modeptr u_modeptr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .mode_acc (mode_acc),
    .mode_wr  (bus_wr),
    .ptr_home (ptr_home),
    .wdata    (bus_wdata),
    .sel_m2   (sel_m2),
    .mode1    (mode1),
    .mode2    (mode2_out)
  );

  uart_regif_rxcnt #(.DEPTH(FIFO_DEPTH)) u_rxcnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .push    (rx_push),
    .pop_req (rd_rx),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  uart_regif_outport #(.OPW(DW)) u_outport (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .set_we    (we_set),
    .clr_we    (we_clr),
    .wdata     (bus_wdata),
    .flow_en   (mode1.rx_flow),
    .rx_start  (rx_start),
    .fifo_full (fifo_full),
    .op_bits   (outport_out)
  );

  logic [DW-1:0] cs_q, aux_q, imr_q, hi_q, lo_q, vec_q, tx_q;
  logic          txl_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cs_q  <= '0;
      aux_q <= '0;
      imr_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      vec_q <= VEC_RESET;
      tx_q  <= '0;
      txl_q <= 1'b0;
    end else begin
      if (we_cs)  cs_q  <= bus_wdata;
      if (we_aux) aux_q <= bus_wdata;
      if (we_imr) imr_q <= bus_wdata;
      if (we_hi)  hi_q  <= bus_wdata;
      if (we_lo)  lo_q  <= bus_wdata;
      if (we_vec) vec_q <= bus_wdata;
      if (we_tx)  tx_q  <= bus_wdata;
      txl_q <= we_tx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      case (bus_addr)
        OFS_MODE:    bus_rdata = sel_m2 ? mode2_out : DW'(mode1);
        OFS_STAT_CS: bus_rdata = {stat_hi_in, fifo_full, !fifo_empty};
        OFS_RXTX:    bus_rdata = fifo_empty ? '0 : rx_head_in;
        OFS_CHG_AUX: bus_rdata = ipchg_in;
        OFS_IRQ:     bus_rdata = irq_stat_in;
        OFS_PRE_HI:  bus_rdata = hi_q;
        OFS_PRE_LO:  bus_rdata = lo_q;
        OFS_VEC:     bus_rdata = vec_q;
        OFS_INPORT:  bus_rdata = inport_in;
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign mode1_out    = DW'(mode1);
  assign clk_sel_out  = cs_q;
  assign aux_ctl_out  = aux_q;
  assign irq_mask_out = imr_q;
  assign irq_vec_out  = vec_q;
  assign pre_hi_out   = hi_q;
  assign pre_lo_out   = lo_q;
  assign tx_data_out  = tx_q;
  assign tx_load_out  = txl_q;
  assign rts_out      = outport_out[0];

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    we_tx |=> tx_load_out) else $error("tx pulse"); // R4
  AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !we_tx |=> !tx_load_out) else $error("tx single"); // R4
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_rd && bus_addr == OFS_CMD) |-> (bus_rdata == '0)) else $error("cmd read"); // R10
  AST_EMPTY_RX_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_rx && fifo_empty) |-> (bus_rdata == '0)) else $error("empty rx read"); // R7
endmodule

// File: tb/uart_regif_tb.sv
`timescale 1ns/1ps
module uart_regif_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [5:0] stat_hi_in;
  logic [7:0] ipchg_in, irq_stat_in, inport_in, rx_head_in;
  logic       rx_push, rx_start;
  logic [7:0] mode1_out, mode2_out, clk_sel_out, aux_ctl_out, irq_mask_out, irq_vec_out;
  logic [7:0] pre_hi_out, pre_lo_out, tx_data_out, outport_out;
  logic       tx_load_out, rts_out;

  uart_regif u_dut (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_push();
    @(negedge clk); rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
  endtask

  function automatic logic [7:0] stat_exp(input logic [5:0] hi, input bit full, input bit ne);
    return {hi, full, ne};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] m_cs, m_aux, m_imr, m_hi, m_lo, m_vec, m_op;
    void'($urandom(32'd7321));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    stat_hi_in = 0; ipchg_in = 0; irq_stat_in = 0; inport_in = 0; rx_head_in = 0;
    rx_push = 0; rx_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 mode1", mode1_out, 8'h00);
    chk("R1 mode2", mode2_out, 8'h00);
    chk("R1 imr", irq_mask_out, 8'h00);
    chk("R1 vec", irq_vec_out, 8'h0F);
    chk("R1 outport", outport_out, 8'h00);
    chk("R1 prescale", {pre_hi_out, pre_lo_out}, 16'h0000);
    rd(6'h04, d); chk("R1 fifo empty status", d, 8'h00);

    // R2 pointer advance
    wr(6'h00, 8'h25); chk("R2 mode1 written", mode1_out, 8'h25);
    wr(6'h00, 8'h3C); chk("R2 mode2 written", mode2_out, 8'h3C);
    chk("R2 mode1 kept", mode1_out, 8'h25);
    wr(6'h00, 8'h11); chk("R2 stays on mode2", mode2_out, 8'h11);
    rd(6'h00, d); chk("R2 read mode2", d, 8'h11);
    // R3 other command codes ignored, home code works
    wr(6'h08, 8'h20); rd(6'h00, d); chk("R3 cmd other ignored", d, 8'h11);
    wr(6'h08, 8'h10); rd(6'h00, d); chk("R3 ptr home", d, 8'h25);
    rd(6'h00, d); chk("R2 read advances", d, 8'h11);
    // R10 reads of write-only/unused do not move pointer
    wr(6'h08, 8'h10);
    rd(6'h08, d); chk("R10 cmd read", d, 8'h00);
    rd(6'h38, d); chk("R10 set read", d, 8'h00);
    rd(6'h3C, d); chk("R10 clr read", d, 8'h00);
    rd(6'h24, d); chk("R10 unused read", d, 8'h00);
    rd(6'h00, d); chk("R10 pointer unmoved", d, 8'h25);
    wr(6'h08, 8'h10); wr(6'h00, 8'h05); chk("R9 flow off", mode1_out, 8'h05);

    // R4 direction decode
    stat_hi_in = 6'h3F; rd(6'h04, d); chk("R4 status read", d, stat_exp(6'h3F, 0, 0));
    wr(6'h04, 8'h5A); chk("R4 clksel", clk_sel_out, 8'h5A);
    rd(6'h04, d); chk("R4 status not clksel", d, 8'hFC);
    ipchg_in = 8'h93; rd(6'h10, d); chk("R4 ipchg read", d, 8'h93);
    irq_stat_in = 8'h4E; rd(6'h14, d); chk("R4 isr read", d, 8'h4E);
    wr(6'h0C, 8'hC7);
    chk("R4 tx data", tx_data_out, 8'hC7);
    chk("R4 tx load high", tx_load_out, 1'b1);
    @(negedge clk); chk("R4 tx load one cycle", tx_load_out, 1'b0);

    // random traffic against a model (flow control off)
    m_cs = 8'h5A; m_aux = 0; m_imr = 0; m_hi = 0; m_lo = 0; m_vec = 8'h0F; m_op = 0;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 8);
      v  = 8'($urandom);
      case (op)
        0: begin wr(6'h04, v); m_cs = v; end
        1: begin wr(6'h10, v); m_aux = v; end
        2: begin wr(6'h14, v); m_imr = v; end
        3: begin wr(6'h18, v); m_hi = v; end
        4: begin wr(6'h1C, v); m_lo = v; end
        5: begin wr(6'h30, v); m_vec = v; end
        6: begin wr(6'h38, v); m_op = m_op | v; end
        7: begin wr(6'h3C, v); m_op = m_op & ~v; end
        default: begin
          wr(6'h34, v);
          inport_in = 8'($urandom);
          rd(6'h34, d); chk("R5 inport read", d, inport_in);
        end
      endcase
      chk("R4 clksel/aux/imr", {clk_sel_out, aux_ctl_out, irq_mask_out}, {m_cs, m_aux, m_imr});
      chk("R6 outport", outport_out, m_op);
      if (op >= 3 && op <= 5) begin
        rd(6'h18, d); chk("R5 prescale hi", d, m_hi);
        rd(6'h1C, d); chk("R5 prescale lo", d, m_lo);
        rd(6'h30, d); chk("R5 vector", d, m_vec);
        chk("R5 outputs", {pre_hi_out, pre_lo_out, irq_vec_out}, {m_hi, m_lo, m_vec});
      end
    end

    // R7 FIFO counter
    stat_hi_in = 6'h00;
    wr(6'h3C, 8'hFF); wr(6'h38, 8'h01);
    chk("R6 rts set", rts_out, 1'b1);
    repeat (5) pulse_push();
    rd(6'h04, d); chk("R7 full status", d, 8'h03);
    // R9: flow off, start while full keeps RTS
    pulse_start(); @(negedge clk); chk("R9 rts untouched", rts_out, 1'b1);
    for (int k = 0; k < 4; k++) begin
      rx_head_in = 8'(8'h40 + k);
      rd(6'h0C, d); chk("R7 pop data", d, 8'(8'h40 + k));
    end
    rd(6'h04, d); chk("R7 empty status", d, 8'h00);
    rd(6'h0C, d); chk("R7 empty read zero", d, 8'h00);
    repeat (4) pulse_push();
    rd(6'h04, d); chk("R7 refill no underflow", d, 8'h03);
    rd(6'h20, d); rd(6'h04, d); chk("R10 no pop on unused", d, 8'h03);

    // R8 flow control on
    wr(6'h08, 8'h10); wr(6'h00, 8'h85);
    chk("R8 flow bit", mode1_out[7], 1'b1);
    chk("R8 rts before", rts_out, 1'b1);
    pulse_start(); chk("R8 rts dropped", rts_out, 1'b0);
    @(negedge clk); chk("R8 rts held while full", rts_out, 1'b0);
    rx_head_in = 8'h77;
    rd(6'h0C, d); chk("R8 pop data", d, 8'h77);
    chk("R8 rts not yet", rts_out, 1'b0);
    @(negedge clk); chk("R8 rts restored", rts_out, 1'b1);
    pulse_start(); chk("R8 start not full", rts_out, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule